// File: doc/BRIEF.md
# Lockstep Redundancy Checker

This block wraps the pins of one core so that two identical copies of that core can share a bus and watch each other. A strap pin is sampled while reset is held and picks one of two roles. The role stays fixed until the next reset. In the master role the wrapper passes the core's outputs and their enables to the pads. In the checker role it drives nothing onto the shared bus except the test-data-out pin and its own error pin.

In the checker role the block also compares, for every bit its own core would have driven, the value on the shared bus with the value the local core produced for the same cycle. Both cores run in lockstep on the same instruction stream, so any difference points to a fault in one of them. A difference raises a sticky error output, which only reset clears. The pad interface is split into separate output, output-enable and input vectors, so the tri-state buffers sit in the pad ring outside the block.

Top module: `lockstep_checker`

## Requirements
- R1: The role is taken from `role_strap` at every clock edge while `rst` is high. Strap 1 selects the checker role and strap 0 selects the master role.
- R2: Once `rst` is low, the role does not change, whatever `role_strap` does.
- R3: In the master role, `pad_out` and `pad_oe` equal `core_out` and `core_oe` from the previous clock edge. Bit i of `pad_oe` = 1 means pad i is driven.
- R4: In the checker role, `pad_oe` is all zeros every cycle.
- R5: In both roles, `tdo_out` equals `core_tdo` from the previous clock edge.
- R6: In the checker role, the block compares `bus_in` with the `core_out` captured at the previous edge, using only the bits whose `core_oe` was 1 at that edge. If any such bit differs, `err_out` is 1 after the next clock edge.
- R7: A bus bit whose captured `core_oe` bit was 0 never causes an error, whatever its value.
- R8: Once `err_out` is 1, it stays 1 until `rst` is asserted.
- R9: In the master role, `err_out` stays 0 whatever appears on `bus_in`.
- R10: While `rst` is high, after a clock edge `pad_oe` is all zeros and both `err_out` and `tdo_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_strap | input | 1 | Role strap, sampled during reset (1 = checker) |
| core_out | input | W | Output values from the local core |
| core_oe | input | W | Per-bit output enables from the local core |
| core_tdo | input | 1 | Test-data-out from the local core |
| bus_in | input | W | Values observed on the shared bus pads |
| pad_out | output | W | Registered pad output values |
| pad_oe | output | W | Registered pad output enables |
| tdo_out | output | 1 | Registered test-data-out, driven in both roles |
| err_out | output | 1 | Sticky mismatch flag |

## Verification
The assertions check these behaviours on every cycle:
- the role holds after reset;
- the pads are floated in the checker role;
- the enables and test-data-out follow the core with one cycle of delay in the master role;
- the error flag stays set once raised and stays low in the master role;
- a mismatch on an enabled bit raises the flag, and a mismatch on disabled bits alone leaves it clear.

Only the bench's scenarios can show the following:
- the strap really picks the role at reset;
- a second reset clears a raised flag and can pick the other role;
- the pad values carry the right data across varied patterns while the strap toggles freely after reset.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic {
    ROLE_MASTER  = 1'b0,
    ROLE_CHECKER = 1'b1
  } role_e;
endpackage

// File: rtl/lsc_role_latch.sv
// Captures the role strap while reset is held; frozen afterwards.
module lsc_role_latch
  import lsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  strap,
  output role_e role
);
  always_ff @(posedge clk) begin
    if (rst) begin
      role <= strap ? ROLE_CHECKER : ROLE_MASTER;
    end
  end
endmodule

// File: rtl/lsc_pad_drive.sv
// Registers the core's pin values and gates the enables by role.
module lsc_pad_drive
  import lsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  role_e        role,
  input  logic [W-1:0] core_out,
  input  logic [W-1:0] core_oe,
  input  logic         core_tdo,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         tdo_out
);
  logic drive_en;
  assign drive_en = (role == ROLE_MASTER);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= core_out[i];
        pad_oe[i]  <= core_oe[i] & drive_en;
      end
    end
  end

  // test-data-out is never floated, in either role
  always_ff @(posedge clk) begin
    if (rst) tdo_out <= 1'b0;
    else     tdo_out <= core_tdo;
  end
endmodule

// File: rtl/lsc_compare.sv
// Holds the local core's would-be values one cycle, compares them with
// the shared bus on enabled bits, and keeps a sticky error flag.
module lsc_compare
  import lsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  role_e        role,
  input  logic [W-1:0] core_out,
  input  logic [W-1:0] core_oe,
  input  logic [W-1:0] bus_in,
  output logic         err
);
  logic [W-1:0] want_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] bit_bad;
  logic         any_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= '0;
      mask_q <= '0;
    end else begin
      want_q <= core_out;
      mask_q <= core_oe;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign bit_bad[i] = mask_q[i] & (want_q[i] ^ bus_in[i]);
  end

  assign any_bad = (role == ROLE_CHECKER) && (|bit_bad);

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (any_bad) err <= 1'b1;
  end
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
  import lsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         role_strap,
  input  logic [W-1:0] core_out,
  input  logic [W-1:0] core_oe,
  input  logic         core_tdo,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         tdo_out,
  output logic         err_out
);
  role_e role_q;
  logic  role_chk;

  assign role_chk = (role_q == ROLE_CHECKER);

  lsc_role_latch u_role (
    .clk   (clk),
    .rst   (rst),
    .strap (role_strap),
    .role  (role_q)
  );

  lsc_pad_drive #(.W(W)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .role     (role_q),
    .core_out (core_out),
    .core_oe  (core_oe),
    .core_tdo (core_tdo),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .tdo_out  (tdo_out)
  );

  lsc_compare #(.W(W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .role     (role_q),
    .core_out (core_out),
    .core_oe  (core_oe),
    .bus_in   (bus_in),
    .err      (err_out)
  );
endmodule

// File: rtl/lsc_sva.sv
module lsc_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         role_chk,
  input logic [W-1:0] core_out,
  input logic [W-1:0] core_oe,
  input logic         core_tdo,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] pad_oe,
  input logic         tdo_out,
  input logic         err_out
);
  p_role_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(role_chk));

  p_master_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (!role_chk && !$past(rst)) |-> (pad_oe == $past(core_oe)));

  p_checker_float_r4: assert property (@(posedge clk) disable iff (rst)
    role_chk |-> (pad_oe == '0));

  p_tdo_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tdo_out == $past(core_tdo)));

  p_flag_raise_r6: assert property (@(posedge clk) disable iff (rst)
    (role_chk && !$past(rst) && (((($past(core_out) ^ bus_in) & $past(core_oe))) != '0))
    |=> err_out);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (role_chk && !err_out && !$past(rst) &&
     ((($past(core_out) ^ bus_in) & $past(core_oe)) == '0))
    |=> !err_out);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_out |=> err_out);

  p_master_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !role_chk |-> !err_out);
endmodule

bind lockstep_checker lsc_sva #(.W(W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .role_chk (role_chk),
  .core_out (core_out),
  .core_oe  (core_oe),
  .core_tdo (core_tdo),
  .bus_in   (bus_in),
  .pad_oe   (pad_oe),
  .tdo_out  (tdo_out),
  .err_out  (err_out)
);

// File: tb/lockstep_checker_tb.sv
module lockstep_checker_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         role_strap = 1'b0;
  logic [W-1:0] core_out = '0;
  logic [W-1:0] core_oe = '0;
  logic         core_tdo = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_oe;
  logic         tdo_out;
  logic         err_out;

  always #2.5 clk = ~clk;

  lockstep_checker #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .role_strap(role_strap),
    .core_out(core_out), .core_oe(core_oe), .core_tdo(core_tdo),
    .bus_in(bus_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tdo_out(tdo_out), .err_out(err_out)
  );

  typedef struct {
    logic [W-1:0] out;
    logic [W-1:0] oe;
    logic         tdo;
    logic         err;
    logic         master;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  // bench-side model state
  logic         chk_m  = 0;
  logic [W-1:0] prev_v = '0;
  logic [W-1:0] prev_en = '0;
  logic         err_m  = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.master) begin
          check(pad_oe === e.oe, "R3 pad_oe (master)", pad_oe, e.oe);
          check(pad_out === e.out, "R3 pad_out (master)", pad_out, e.out);
          check(err_out === 1'b0, "R9 err_out in master", {31'b0, err_out}, '0);
        end else begin
          check(pad_oe === '0, "R4 pad_oe floated (checker)", pad_oe, '0);
          check(err_out === e.err, "R6/R7/R8 err_out", {31'b0, err_out}, {31'b0, e.err});
        end
        check(tdo_out === e.tdo, "R5 tdo_out", {31'b0, tdo_out}, {31'b0, e.tdo});
      end
    end
  end

  // driver: one core cycle, with the bus showing the master's value xor corrupt
  task automatic step(input logic [W-1:0] v, input logic [W-1:0] en,
                      input logic t, input logic [W-1:0] corrupt);
    exp_t e;
    logic [W-1:0] bus;
    @(negedge clk);
    bus = prev_v ^ corrupt;
    if (chk_m && ((corrupt & prev_en) != '0)) err_m = 1'b1;
    core_out   = v;
    core_oe    = en;
    core_tdo   = t;
    bus_in     = bus;
    role_strap = 1'($urandom % 2);   // R2: strap moves freely after reset
    e.out = v; e.oe = chk_m ? '0 : en; e.tdo = t; e.err = err_m; e.master = !chk_m;
    q.push_back(e);
    prev_v  = v;
    prev_en = en;
  endtask

  // R1, R10: reset with a chosen strap value
  task automatic do_reset(input logic s);
    wait (q.size() == 0);
    @(negedge clk);
    rst = 1'b1; role_strap = s;
    core_out = '0; core_oe = '0; core_tdo = 1'b1; bus_in = '1;
    repeat (3) @(posedge clk);
    #2;
    check(pad_oe === '0, "R10 pad_oe in reset", pad_oe, '0);
    check(err_out === 1'b0, "R10 err_out in reset", {31'b0, err_out}, '0);
    check(tdo_out === 1'b0, "R10 tdo_out in reset", {31'b0, tdo_out}, '0);
    @(negedge clk);
    rst = 1'b0; core_tdo = 1'b0; bus_in = '0;
    chk_m = s; prev_v = '0; prev_en = '0; err_m = 1'b0;
  endtask

  task automatic finish_run();
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: strap 0 -> master; R3, R5, R9 with bus corruption ignored
    do_reset(1'b0);
    step(32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1, '0);
    step(32'h1234_5678, 32'h0000_FFFF, 1'b0, 32'h0000_0001);
    step(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, 32'hFFFF_FFFF);
    for (int i = 0; i < 20; i++)
      step($urandom, $urandom, 1'($urandom % 2), $urandom);

    // R1: strap 1 -> checker; R4 floated, R2 strap toggles ignored
    do_reset(1'b1);
    for (int i = 0; i < 10; i++)
      step($urandom, $urandom, 1'($urandom % 2), '0);
    // R7: corrupt only bits whose enable was 0
    step(32'hAAAA_AAAA, 32'h0000_FFFF, 1'b0, '0);
    step(32'h5555_5555, 32'hFFFF_0000, 1'b1, 32'hFFFF_0000);
    step(32'h0, 32'h0, 1'b0, 32'h0000_FFFF);
    step(32'h0, 32'h0, 1'b0, 32'hFFFF_FFFF);
    // R6: single enabled bit wrong
    step(32'h8000_0000, 32'h8000_0000, 1'b1, '0);
    step(32'h0, 32'hFFFF_FFFF, 1'b0, 32'h8000_0000);
    // R8: flag stays set through clean cycles
    for (int i = 0; i < 8; i++)
      step($urandom, $urandom, 1'($urandom % 2), '0);

    // R8/R10: reset clears the flag; checker again, then master
    do_reset(1'b1);
    for (int i = 0; i < 6; i++)
      step($urandom, $urandom, 1'($urandom % 2), '0);
    step(32'h0000_0010, 32'h0000_0010, 1'b0, '0);
    step(32'h0, 32'h0, 1'b0, 32'h0000_0010);
    step(32'h0, 32'h0, 1'b1, '0);
    do_reset(1'b0);
    for (int i = 0; i < 6; i++)
      step($urandom, $urandom, 1'($urandom % 2), $urandom);
    finish_run();
  end
endmodule